// File: doc/BRIEF.md
# Full-Frame CCD Readout Clock Sequencer

This block produces the digital timing lines that drive a single-output full-frame CCD through one complete frame. A start command begins an integration hold of programmable length. The sequencer then reads the frame out line by line. For each line it runs a vertical transfer that moves one row into the horizontal register. A settle interval follows, and then the horizontal shift clocks the row out pixel by pixel. The outputs are logic-level lines, to be level-shifted off this block: two vertical phases, two complementary horizontal phases, a separately driven last-horizontal-phase clock whose falling edge dumps a packet onto the sense node, and the reset gate. The block also issues two one-cycle strobes that tell the sampling electronics when the reset level and the video level are valid.

Every pixel takes five clock ticks. Tick 0 pulses the reset gate, and the horizontal phase returns high in the same tick. Tick 1 strobes the reset level. Tick 2 lowers the horizontal phase and the dump clock, which moves one packet onto the sense node. Tick 3 lets the output settle. Tick 4 strobes the video level. The reset gate therefore never fires between a dump and the video sample of that dump. The first horizontal phase stays high across the whole vertical transfer, so the falling vertical edge that loads a line always sees it high. The line length and the frame height are parameters. The integration length, the vertical phase width, the inter-phase guard and the settle time are inputs.

Top module: `ccd_seq`

## Requirements
- R1: After reset, and whenever no frame is in progress, v1_o, v2_o, h2_o, rg_o, shr_o, shs_o, busy_o and done_o are 0, and h1_o and h1l_o are 1.
- R2: start_i sampled high while idle begins a frame. busy_o rises at the next edge, and v1_o and v2_o stay low for exactly exp_ticks_i+1 cycles of integration. start_i while busy_o is 1 has no effect on the frame.
- R3: Each line transfer runs in this order: v1_o high for vwidth_i+1 cycles, both low for guard_i+1 cycles, v2_o high for vwidth_i+1 cycles, and both low for guard_i+1 cycles. v1_o and v2_o are never high together.
- R4: h1_o is 1 in every cycle in which v2_o has just fallen.
- R5: The first h1l_o falling edge of a line comes guard_i+settle_i+4 cycles after the falling edge of v2_o for that line.
- R6: h2_o is always the complement of h1_o, and h1l_o always equals h1_o.
- R7: Within each 5-cycle pixel: rg_o pulses while h1_o is high, shr_o pulses in the next cycle, h1l_o falls one cycle after shr_o, and shs_o pulses two cycles after that fall.
- R8: Each line has exactly NUM_PIX h1l_o falling edges, and each frame has exactly NUM_LINES v2_o falling edges.
- R9: rg_o is never high between an h1l_o fall and the shs_o pulse that follows it.
- R10: A frame keeps busy_o high for (exp+1) + NUM_LINES*(2*vwidth+2*guard+settle+5+5*NUM_PIX) + 1 cycles. done_o is a single one-cycle pulse in the last of those cycles, and the block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock, one tick per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame (only honoured when idle) |
| exp_ticks_i | input | EXP_W | Integration length minus one, in ticks |
| vwidth_i | input | PH_W | Vertical phase high time minus one |
| guard_i | input | PH_W | Non-overlap guard between vertical phases, minus one |
| settle_i | input | PH_W | Horizontal settle time before shifting, minus one |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| h1_o | output | 1 | Horizontal phase 1 |
| h2_o | output | 1 | Horizontal phase 2 |
| h1l_o | output | 1 | Last horizontal phase (dump clock) |
| rg_o | output | 1 | Reset gate |
| shr_o | output | 1 | Reset-level sample strobe |
| shs_o | output | 1 | Video-level sample strobe |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench runs a sweep of zero and non-zero integration, phase, guard and settle values on a three-pixel, two-line configuration and measures every edge spacing against closed-form values. A sequencer that loaded lines with H1 low, let the two vertical phases overlap, or dropped or added one shift per line would give wrong edge counts at the line or frame boundary. An off-by-one in any duration counter would also move the measured intervals. The bench places a reset-gate pulse check inside every dump-to-sample window, so a misordered pixel phase is caught. It also pulses start again mid-frame; a block that re-armed would lengthen the busy interval or produce a second done pulse.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INTEG,
    ST_VXFER,
    ST_HSETL,
    ST_HSHIFT,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    VS_V1,
    VS_GA,
    VS_V2,
    VS_GB
  } vseg_e;

  localparam int unsigned PIX_TICKS = 5;
  localparam logic [2:0]  TK_RG     = 3'd0;
  localparam logic [2:0]  TK_SHR    = 3'd1;
  localparam logic [2:0]  TK_DUMP   = 3'd2;
  localparam logic [2:0]  TK_SHS    = 3'd4;
  localparam logic [2:0]  TK_LAST   = 3'(PIX_TICKS - 1);

endpackage

// File: rtl/ccd_seq_cnt.sv
module ccd_seq_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);

  logic [W-1:0] cnt_d;

  assign zero = (cnt == '0);

  always_comb begin
    cnt_d = cnt;
    if (load)
      cnt_d = load_val;
    else if (dec && !zero)
      cnt_d = cnt - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load || dec)
      cnt <= cnt_d;
  end

endmodule

// File: rtl/ccd_seq_pix.sv
module ccd_seq_pix
  import ccd_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic tick_last,
  output logic h1,
  output logic h1l,
  output logic rg,
  output logic shr,
  output logic shs
);

  logic [2:0] tick_q, tick_d;

  assign tick_last = active && (tick_q == TK_LAST);

  always_comb begin
    tick_d = '0;
    if (active && (tick_q != TK_LAST))
      tick_d = tick_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tick_q <= '0;
    else
      tick_q <= tick_d;
  end

  // phase-1 and the dump clock are separate drivers with the same timing
  assign h1  = !active || (tick_q < TK_DUMP);
  assign h1l = !active || (tick_q < TK_DUMP);
  assign rg  = active && (tick_q == TK_RG);
  assign shr = active && (tick_q == TK_SHR);
  assign shs = active && (tick_q == TK_SHS);

endmodule

// File: rtl/ccd_seq.sv
module ccd_seq
  import ccd_seq_pkg::*;
#(
  parameter int unsigned NUM_PIX   = 4641,
  parameter int unsigned NUM_LINES = 3695,
  parameter int unsigned EXP_W     = 32,
  parameter int unsigned PH_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [EXP_W-1:0] exp_ticks_i,
  input  logic [PH_W-1:0]  vwidth_i,
  input  logic [PH_W-1:0]  guard_i,
  input  logic [PH_W-1:0]  settle_i,
  output logic             v1_o,
  output logic             v2_o,
  output logic             h1_o,
  output logic             h2_o,
  output logic             h1l_o,
  output logic             rg_o,
  output logic             shr_o,
  output logic             shs_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int unsigned PIX_W  = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1;
  localparam int unsigned LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int unsigned DUR_W  = (EXP_W >= PH_W) ? EXP_W : PH_W;

  seq_state_e state_q, state_d;
  vseg_e      vseg_q, vseg_d;

  logic             dur_load, dur_dec, dur_zero;
  logic [DUR_W-1:0] dur_val, dur_cnt;
  logic             pix_load, pix_dec, pix_zero;
  logic [PIX_W-1:0] pix_cnt;
  logic             line_load, line_dec, line_zero;
  logic [LINE_W-1:0] line_cnt;
  logic             shift_act, tick_last, h1_int;

  ccd_seq_cnt #(.W(DUR_W)) u_dur (
    .clk(clk_i), .rst_n(rst_ni), .load(dur_load), .load_val(dur_val),
    .dec(dur_dec), .cnt(dur_cnt), .zero(dur_zero));

  ccd_seq_cnt #(.W(PIX_W)) u_pix_cnt (
    .clk(clk_i), .rst_n(rst_ni), .load(pix_load), .load_val(PIX_W'(NUM_PIX - 1)),
    .dec(pix_dec), .cnt(pix_cnt), .zero(pix_zero));

  ccd_seq_cnt #(.W(LINE_W)) u_line_cnt (
    .clk(clk_i), .rst_n(rst_ni), .load(line_load), .load_val(LINE_W'(NUM_LINES - 1)),
    .dec(line_dec), .cnt(line_cnt), .zero(line_zero));

  assign shift_act = (state_q == ST_HSHIFT);

  ccd_seq_pix u_pix (
    .clk(clk_i), .rst_n(rst_ni), .active(shift_act), .tick_last(tick_last),
    .h1(h1_int), .h1l(h1l_o), .rg(rg_o), .shr(shr_o), .shs(shs_o));

  // next-state process
  always_comb begin
    state_d   = state_q;
    vseg_d    = vseg_q;
    dur_load  = 1'b0;
    dur_val   = '0;
    dur_dec   = 1'b0;
    pix_load  = 1'b0;
    pix_dec   = 1'b0;
    line_load = 1'b0;
    line_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_INTEG;
          dur_load  = 1'b1;
          dur_val   = DUR_W'(exp_ticks_i);
          line_load = 1'b1;
        end
      end
      ST_INTEG: begin
        if (dur_zero) begin
          state_d  = ST_VXFER;
          vseg_d   = VS_V1;
          dur_load = 1'b1;
          dur_val  = DUR_W'(vwidth_i);
        end else begin
          dur_dec = 1'b1;
        end
      end
      ST_VXFER: begin
        if (!dur_zero) begin
          dur_dec = 1'b1;
        end else begin
          dur_load = 1'b1;
          unique case (vseg_q)
            VS_V1: begin vseg_d = VS_GA; dur_val = DUR_W'(guard_i);  end
            VS_GA: begin vseg_d = VS_V2; dur_val = DUR_W'(vwidth_i); end
            VS_V2: begin vseg_d = VS_GB; dur_val = DUR_W'(guard_i);  end
            default: begin
              state_d = ST_HSETL;
              dur_val = DUR_W'(settle_i);
            end
          endcase
        end
      end
      ST_HSETL: begin
        if (dur_zero) begin
          state_d  = ST_HSHIFT;
          pix_load = 1'b1;
        end else begin
          dur_dec = 1'b1;
        end
      end
      ST_HSHIFT: begin
        if (tick_last) begin
          if (!pix_zero) begin
            pix_dec = 1'b1;
          end else if (line_zero) begin
            state_d = ST_DONE;
          end else begin
            line_dec = 1'b1;
            state_d  = ST_VXFER;
            vseg_d   = VS_V1;
            dur_load = 1'b1;
            dur_val  = DUR_W'(vwidth_i);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vseg_q  <= VS_V1;
    end else begin
      state_q <= state_d;
      vseg_q  <= vseg_d;
    end
  end

  assign v1_o   = (state_q == ST_VXFER) && (vseg_q == VS_V1);
  assign v2_o   = (state_q == ST_VXFER) && (vseg_q == VS_V2);
  assign h1_o   = h1_int;
  assign h2_o   = !h1_int;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk
  import ccd_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input seq_state_e state,
  input logic       v1,
  input logic       v2,
  input logic       h1,
  input logic       h2,
  input logic       h1l,
  input logic       rg,
  input logic       shr,
  input logic       shs,
  input logic       busy,
  input logic       done
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!v1 && !v2 && !rg && !shr && !shs && !done && h1 && h1l)); // R1
  AST_INTEG_V_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INTEG) |-> (!v1 && !v2)); // R2
  AST_V_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(v1 && v2)); // R3
  AST_H1_AT_V2_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(v2) |-> h1); // R4
  AST_H_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (h1 != h2) && (h1l == h1)); // R6
  AST_SHR_AFTER_RG: assert property (@(posedge clk) disable iff (!rst_n)
    shr |-> $past(rg)); // R7
  AST_SHS_AFTER_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
    shs |-> (!h1l && $past(!h1l))); // R7
  AST_RG_OUTSIDE_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
    rg |-> h1l); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R10

endmodule

bind ccd_seq ccd_seq_chk u_chk (
  .clk(clk_i), .rst_n(rst_ni), .state(state_q),
  .v1(v1_o), .v2(v2_o), .h1(h1_o), .h2(h2_o), .h1l(h1l_o),
  .rg(rg_o), .shr(shr_o), .shs(shs_o), .busy(busy_o), .done(done_o));

// File: tb/tb_ccd_seq.sv
module tb_ccd_seq;

  localparam int P = 3;
  localparam int L = 2;

  logic clk, rst_n, start;
  logic [31:0] exp_t;
  logic [7:0]  vw, gd, st;
  logic v1, v2, h1, h2, h1l, rg, shr, shs, busy, done;

  int checks = 0, errors = 0, wd = 0;
  int c_exp, c_w, c_g, c_s;
  int cyc, v1_rise, v1_fall, v2_rise, v2_fall, rg_cyc, shr_cyc, dump_cyc;
  int line_falls, lines_seen, busy_cnt, done_cnt, integ_cnt;
  bit mon_en, seen_v1, armed, first_pending;
  logic pv1, pv2, ph1l;

  ccd_seq #(.NUM_PIX(P), .NUM_LINES(L), .EXP_W(32), .PH_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .exp_ticks_i(exp_t),
    .vwidth_i(vw), .guard_i(gd), .settle_i(st),
    .v1_o(v1), .v2_o(v2), .h1_o(h1), .h2_o(h2), .h1l_o(h1l), .rg_o(rg),
    .shr_o(shr), .shs_o(shs), .busy_o(busy), .done_o(done));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      cyc++;
      if (busy) busy_cnt++;
      if (busy && !seen_v1 && !v1) begin
        integ_cnt++;
        if (v2) chk(0, "R2 v2 during integration", 1, 0);
      end
      if (h2 == h1)  chk(0, "R6 h2 complement", h2, !h1);
      if (h1l != h1) chk(0, "R6 h1l copy", h1l, h1);
      if (v1 && v2)  chk(0, "R3 overlap", 1, 0);
      if (v1 && !pv1) begin
        if (!seen_v1) chk(integ_cnt == c_exp + 1, "R2 integration length", integ_cnt, c_exp + 1);
        seen_v1 = 1;
        v1_rise = cyc;
      end
      if (!v1 && pv1) begin
        chk(cyc - v1_rise == c_w + 1, "R3 v1 width", cyc - v1_rise, c_w + 1);
        v1_fall = cyc;
      end
      if (v2 && !pv2) begin
        chk(cyc - v1_fall == c_g + 1, "R3 guard", cyc - v1_fall, c_g + 1);
        v2_rise = cyc;
      end
      if (!v2 && pv2) begin
        chk(cyc - v2_rise == c_w + 1, "R3 v2 width", cyc - v2_rise, c_w + 1);
        chk(h1 == 1'b1, "R4 h1 at v2 fall", h1, 1);
        if (lines_seen > 0) chk(line_falls == P, "R8 falls per line", line_falls, P);
        line_falls = 0;
        lines_seen++;
        v2_fall = cyc;
        first_pending = 1;
      end
      if (rg) begin
        chk(h1 == 1'b1, "R7 rg with h1 high", h1, 1);
        if (armed) chk(0, "R9 rg inside dump window", 1, 0);
        rg_cyc = cyc;
      end
      if (shr) chk(cyc == rg_cyc + 1, "R7 shr after rg", cyc - rg_cyc, 1);
      if (!h1l && ph1l) begin
        line_falls++;
        chk(cyc == shr_cyc_next(), "R7 dump after shr", cyc - shr_cyc, 1);
        if (first_pending) begin
          chk(cyc - v2_fall == c_g + c_s + 4, "R5 settle to first dump", cyc - v2_fall, c_g + c_s + 4);
          first_pending = 0;
        end
        armed = 1;
        dump_cyc = cyc;
      end
      if (shr) shr_cyc = cyc;
      if (shs) begin
        chk(cyc == dump_cyc + 2, "R7 shs after dump", cyc - dump_cyc, 2);
        armed = 0;
      end
      if (done) begin
        done_cnt++;
        chk(line_falls == P, "R8 falls on last line", line_falls, P);
      end
      pv1 = v1; pv2 = v2; ph1l = h1l;
    end
  end

  function automatic int shr_cyc_next();
    return shr_cyc + 1;
  endfunction

  task automatic run_frame(input int e, input int w, input int g, input int s, input bit poke);
    int expct;
    @(negedge clk);
    mon_en = 0;
    c_exp = e; c_w = w; c_g = g; c_s = s;
    exp_t = 32'(e); vw = 8'(w); gd = 8'(g); st = 8'(s);
    busy_cnt = 0; done_cnt = 0; integ_cnt = 0; lines_seen = 0; line_falls = 0;
    seen_v1 = 0; armed = 0; first_pending = 0;
    pv1 = v1; pv2 = v2; ph1l = h1l;
    mon_en = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (e + 3) @(negedge clk);
      start = 1'b1;                     // R2: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    expct = (e + 1) + L * (2*w + 2*g + s + 5 + 5*P) + 1;
    chk(busy_cnt == expct, "R10 busy length", busy_cnt, expct);
    chk(done_cnt == 1, "R10 single done pulse", done_cnt, 1);
    chk(lines_seen == L, "R8 lines per frame", lines_seen, L);
    chk(busy == 1'b0, "R10 back to idle", busy, 0);
    chk(h1 && h1l && !v1 && !v2 && !rg, "R1 idle levels after frame", {h1, h1l, v1, v2, rg}, 5'b11000);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mon_en = 0;
    exp_t = '0; vw = '0; gd = '0; st = '0;
    cyc = 0; rg_cyc = 0; shr_cyc = 0; dump_cyc = 0;
    v1_rise = 0; v1_fall = 0; v2_rise = 0; v2_fall = 0;
    pv1 = 0; pv2 = 0; ph1l = 1;
    repeat (3) @(negedge clk);
    chk(!v1 && !v2 && !h2 && !rg && !shr && !shs && !busy && !done,
        "R1 reset lows", {v1, v2, h2, rg, shr, shs, busy, done}, 0);
    chk(h1 && h1l, "R1 reset highs", {h1, h1l}, 2'b11);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy, "R1 idle without start", busy, 0);
    for (int e = 0; e <= 3; e += 3)
      for (int w = 0; w <= 2; w += 2)
        for (int g = 0; g <= 1; g++)
          for (int s = 0; s <= 2; s += 2)
            run_frame(e, w, g, s, 1'b0);
    run_frame(4, 1, 1, 1, 1'b1);
    run_frame(0, 0, 0, 0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule